// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block finds the translation entry for one virtual page in a hashed page table kept in memory. A lookup starts with a hash value, a compare tag and the page shift of the segment that holds the page. The block turns the hash into the address of an eight-entry group and reads the group one entry at a time through a read port that allows one read in flight and any response delay. Each entry is tested against the tag, the pass flag and a page-size rule. If no entry in the primary group qualifies, the block searches a second group, which it finds from the inverted hash.

When the lookup ends, the block pulses `done` for one cycle. At that point it reports hit or miss, both doublewords of the winning entry, and the entry's byte offset from the table base. These results stay on the outputs until the next lookup begins. The block does not fill translation caches, update history bits or look up segments.

Top module: `hpt_group_search`

## Requirements
- R1: An entry qualifies only when its valid flag, bit 0 of the first doubleword, is 1.
- R2: The pass flag of an entry, bit 1 of the first doubleword, must be 0 during the primary pass and 1 during the secondary pass.
- R3: The tag field, bits [63:7] of the first doubleword, must equal the requested tag.
- R4: When the page shift is 12, an entry passes the size rule whatever its second doubleword holds.
- R5: When the page shift is 16, an entry passes the size rule only if bits [15:12] of its second doubleword equal 4'b0001.
- R6: When the page shift is 24, an entry passes the size rule only if bits [19:12] of its second doubleword are all zero.
- R7: Any other page shift value rejects every entry. An entry that is rejected is skipped and the scan goes on to the next entry, so a lookup in which every entry is rejected ends as a miss after 16 reads.
- R8: The primary group begins at `base + ((hash & mask) << 7)`. Entries are 16 bytes apart and are read in ascending index order, and the first entry that qualifies ends the search.
- R9: The secondary pass begins only after all eight primary entries have been rejected. It scans the group at `base + ((~hash & mask) << 7)`.
- R10: On a hit, the outputs give the entry's two doublewords and the offset `((h & mask) << 7) + 16*index`, where h is the hash used by the pass that hit. On a miss, `hit` is 0 and the offset is all ones.
- R11: Each read request lasts one cycle, and no new request is issued until the response to the previous one has come back.
- R12: After reset the block is idle with no request and no `done`. `done` is a one-cycle pulse at the end of each lookup, and the results stay stable after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a lookup; accepted only while idle |
| hash | input | HASH_W | Primary hash value |
| tag | input | TAG_W | Requested compare tag |
| pshift | input | 5 | Segment page shift |
| tbl_base | input | ADDR_W | Byte address of the table |
| tbl_mask | input | HASH_W | Mask applied to the hash |
| busy | output | 1 | A lookup is in progress |
| done | output | 1 | One-cycle pulse when a lookup ends |
| hit | output | 1 | The last lookup found an entry |
| ent_dw0 | output | 64 | First doubleword of the entry found |
| ent_dw1 | output | 64 | Second doubleword of the entry found |
| ent_offset | output | ADDR_W | Offset of the entry from the base, all ones on a miss |
| mem_req | output | 1 | Read request, one cycle long |
| mem_addr | output | ADDR_W | Address of the 16-byte entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Entry data: [63:0] first doubleword, [127:64] second |

## Verification
Results are not due at a fixed number of cycles after `start`. Each read costs one request cycle plus whatever delay the memory adds, and a lookup takes between one and sixteen reads. The results are due in the cycle in which `done` is high, one clock edge after the response that decided the lookup. The bench therefore polls `done` on falling edges and samples hit, offset and data in that same cycle. It samples them again one cycle later to confirm that `done` has dropped and the results have held. The memory model adds a random delay of zero to three cycles to each read and logs every request address. The bench checks that log against the address sequence it expects, which tests the scan order and the point at which the secondary pass begins.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

   localparam int DW_W        = 64;
   localparam int ENTRY_BYTES = 16;
   localparam int PS_W        = 5;
   localparam int VALID_POS   = 0;
   localparam int PASS_POS    = 1;

   typedef enum logic [1:0] {
      SC_IDLE,
      SC_ISSUE,
      SC_WAIT,
      SC_DONE
   } scan_state_t;

   // Page-size acceptance rule of the second doubleword against the segment shift
   function automatic logic size_rule_ok(input logic [DW_W-1:0] dw1,
                                         input logic [PS_W-1:0] ps);
      logic ok;
      case (ps)
         5'd12:   ok = 1'b1;
         5'd16:   ok = (dw1[15:12] == 4'b0001);
         5'd24:   ok = (dw1[19:12] == 8'h00);
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/hpt_group_addr.sv
module hpt_group_addr #(
   parameter int HASH_W    = 20,
   parameter int ADDR_W    = 40,
   parameter int GRP_SHIFT = 7
) (
   input  logic [HASH_W-1:0] hash,
   input  logic [HASH_W-1:0] mask,
   input  logic [ADDR_W-1:0] base,
   input  logic              second,
   output logic [ADDR_W-1:0] grp_off,
   output logic [ADDR_W-1:0] grp_addr
);
   logic [HASH_W-1:0] h_sel;

   always_comb begin
      h_sel    = second ? ~hash : hash;
      grp_off  = ADDR_W'(h_sel & mask) << GRP_SHIFT;
      grp_addr = base + grp_off;
   end
endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match
   import hpt_pkg::*;
#(
   parameter int TAG_W = 57
) (
   input  logic [DW_W-1:0]  dw0,
   input  logic [DW_W-1:0]  dw1,
   input  logic [TAG_W-1:0] tag,
   input  logic             second,
   input  logic [PS_W-1:0]  pshift,
   output logic             accept
);
   logic valid_ok, pass_ok, tag_ok, size_ok;

   always_comb begin
      valid_ok = dw0[VALID_POS];
      pass_ok  = (dw0[PASS_POS] == second);
      tag_ok   = (dw0[DW_W-1 -: TAG_W] == tag);
      size_ok  = size_rule_ok(dw1, pshift);
      accept   = valid_ok & pass_ok & tag_ok & size_ok;
   end
endmodule

// File: rtl/hpt_scan_ctrl.sv
module hpt_scan_ctrl
   import hpt_pkg::*;
#(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             rvalid,
   input  logic             accept,
   output logic             load,
   output logic             mem_req,
   output logic             busy,
   output logic             done,
   output logic             cap_hit,
   output logic             cap_miss,
   output logic             second,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   scan_state_t state;
   logic        last_entry;

   always_comb begin
      last_entry = (idx == LAST_IDX);
      load       = (state == SC_IDLE) && start;
      mem_req    = (state == SC_ISSUE);
      busy       = (state != SC_IDLE);
      done       = (state == SC_DONE);
      cap_hit    = (state == SC_WAIT) && rvalid && accept;
      cap_miss   = (state == SC_WAIT) && rvalid && !accept && last_entry && second;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SC_IDLE;
         idx    <= '0;
         second <= 1'b0;
      end else begin
         case (state)
            SC_IDLE: if (start) begin
               state  <= SC_ISSUE;
               idx    <= '0;
               second <= 1'b0;
            end
            SC_ISSUE: state <= SC_WAIT;
            SC_WAIT: if (rvalid) begin
               if (accept) begin
                  state <= SC_DONE;
               end else if (!last_entry) begin
                  idx   <= idx + 1'b1;
                  state <= SC_ISSUE;
               end else if (!second) begin
                  second <= 1'b1;
                  idx    <= '0;
                  state  <= SC_ISSUE;
               end else begin
                  state <= SC_DONE;
               end
            end
            default: state <= SC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search
   import hpt_pkg::*;
#(
   parameter int HASH_W  = 20,
   parameter int ADDR_W  = 40,
   parameter int TAG_W   = 57,
   parameter int ENTRIES = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [HASH_W-1:0]   hash,
   input  logic [TAG_W-1:0]    tag,
   input  logic [PS_W-1:0]     pshift,
   input  logic [ADDR_W-1:0]   tbl_base,
   input  logic [HASH_W-1:0]   tbl_mask,
   output logic                busy,
   output logic                done,
   output logic                hit,
   output logic [DW_W-1:0]     ent_dw0,
   output logic [DW_W-1:0]     ent_dw1,
   output logic [ADDR_W-1:0]   ent_offset,
   output logic                mem_req,
   output logic [ADDR_W-1:0]   mem_addr,
   input  logic                mem_rvalid,
   input  logic [2*DW_W-1:0]   mem_rdata
);
   localparam int IDX_W     = $clog2(ENTRIES);
   localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);
   localparam int GRP_SHIFT = IDX_W + ENT_SHIFT;

   // Elaboration-time parameter checks
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (ADDR_W < HASH_W + GRP_SHIFT) begin : g_bad_addr
      $error("ADDR_W too narrow for the shifted hash");
   end
   if (TAG_W < 1 || TAG_W > DW_W - 2) begin : g_bad_tag
      $error("TAG_W must leave room for the valid and pass flags");
   end

   logic [HASH_W-1:0] hash_q, mask_q;
   logic [TAG_W-1:0]  tag_q;
   logic [PS_W-1:0]   pshift_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] grp_off, grp_addr, ent_rel;
   logic [IDX_W-1:0]  idx;
   logic              second, accept, load, cap_hit, cap_miss;

   hpt_group_addr #(.HASH_W(HASH_W), .ADDR_W(ADDR_W), .GRP_SHIFT(GRP_SHIFT)) u_addr (
      .hash(hash_q), .mask(mask_q), .base(base_q), .second(second),
      .grp_off(grp_off), .grp_addr(grp_addr)
   );

   hpt_entry_match #(.TAG_W(TAG_W)) u_match (
      .dw0(mem_rdata[DW_W-1:0]), .dw1(mem_rdata[2*DW_W-1:DW_W]),
      .tag(tag_q), .second(second), .pshift(pshift_q), .accept(accept)
   );

   hpt_scan_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .rvalid(mem_rvalid), .accept(accept),
      .load(load), .mem_req(mem_req), .busy(busy), .done(done),
      .cap_hit(cap_hit), .cap_miss(cap_miss), .second(second), .idx(idx)
   );

   always_comb begin
      ent_rel  = ADDR_W'(idx) << ENT_SHIFT;
      mem_addr = grp_addr + ent_rel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hash_q     <= '0;
         mask_q     <= '0;
         tag_q      <= '0;
         pshift_q   <= '0;
         base_q     <= '0;
         hit        <= 1'b0;
         ent_dw0    <= '0;
         ent_dw1    <= '0;
         ent_offset <= '1;
      end else begin
         if (load) begin
            hash_q   <= hash;
            mask_q   <= tbl_mask;
            tag_q    <= tag;
            pshift_q <= pshift;
            base_q   <= tbl_base;
         end
         if (cap_hit) begin
            hit        <= 1'b1;
            ent_dw0    <= mem_rdata[DW_W-1:0];
            ent_dw1    <= mem_rdata[2*DW_W-1:DW_W];
            ent_offset <= grp_off + ent_rel;
         end else if (cap_miss) begin
            hit        <= 1'b0;
            ent_dw0    <= '0;
            ent_dw1    <= '0;
            ent_offset <= '1;
         end
      end
   end
endmodule

// File: rtl/hpt_group_search_chk.sv
module hpt_group_search_chk #(
   parameter int ADDR_W = 40,
   parameter int TAG_W  = 57
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              hit,
   input logic [ADDR_W-1:0] ent_offset,
   input logic [63:0]       ent_dw0,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [TAG_W-1:0]  tag_q
);
   // R11: a request never lasts two cycles
   a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R8: requests target 16-byte entry boundaries
   a_r8_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[3:0] == 4'h0));

   // R12: done is a single-cycle pulse and returns the block to idle
   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R10: a miss reports the all-ones offset
   a_r10_miss_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !hit) |-> (&ent_offset));

   // R1: a reported entry carries its valid flag
   a_r1_valid_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (done && hit) |-> ent_dw0[0]);

   // R3: a reported entry carries the requested tag
   a_r3_tag_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (done && hit) |-> (ent_dw0[63 -: TAG_W] == tag_q));
endmodule

bind hpt_group_search hpt_group_search_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .hit(hit),
   .ent_offset(ent_offset), .ent_dw0(ent_dw0), .mem_req(mem_req),
   .mem_addr(mem_addr), .tag_q(tag_q)
);

// File: tb/hpt_group_search_test.sv
`timescale 1ns/1ps
module hpt_group_search_test;
   localparam int HASH_W = 20;
   localparam int ADDR_W = 40;
   localparam int TAG_W  = 57;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [HASH_W-1:0]  hash = '0;
   logic [TAG_W-1:0]   tag = '0;
   logic [4:0]         pshift = '0;
   logic [ADDR_W-1:0]  tbl_base = '0;
   logic [HASH_W-1:0]  tbl_mask = '0;
   logic               busy, done, hit, mem_req, mem_rvalid;
   logic [63:0]        ent_dw0, ent_dw1;
   logic [ADDR_W-1:0]  ent_offset, mem_addr;
   logic [127:0]       mem_rdata;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   hpt_group_search #(.HASH_W(HASH_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .hash(hash), .tag(tag),
      .pshift(pshift), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
      .busy(busy), .done(done), .hit(hit), .ent_dw0(ent_dw0), .ent_dw1(ent_dw1),
      .ent_offset(ent_offset), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   // ---------------- memory model ----------------
   logic [127:0]      mem [logic [ADDR_W-1:0]];
   logic [ADDR_W-1:0] got_q[$];
   bit                pend = 0;
   int                lat = 0;
   logic [ADDR_W-1:0] pend_addr = '0;
   int                overlap_err = 0;

   initial begin
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
   end

   function automatic logic [127:0] rd(input logic [ADDR_W-1:0] a);
      if (mem.exists(a)) return mem[a];
      return '0;
   endfunction

   always @(negedge clk) begin
      mem_rvalid = 1'b0;
      if (pend) begin
         if (mem_req) overlap_err++;
         if (lat == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = rd(pend_addr);
            pend       = 0;
         end else begin
            lat--;
         end
      end else if (mem_req) begin
         pend      = 1;
         pend_addr = mem_addr;
         lat       = int'($urandom_range(0, 3));
         got_q.push_back(mem_addr);
      end
   end

   // ---------------- reference model ----------------
   function automatic bit size_pass(input logic [63:0] dw1, input logic [4:0] ps);
      if (ps == 5'd12) return 1;
      if (ps == 5'd16) return dw1[15:12] == 4'd1;
      if (ps == 5'd24) return dw1[19:12] == 8'd0;
      return 0;
   endfunction

   function automatic logic [ADDR_W-1:0] grp_rel(input logic [HASH_W-1:0] h,
                                                 input logic [HASH_W-1:0] m);
      return ADDR_W'(h & m) << 7;
   endfunction

   bit                exp_hit;
   logic [ADDR_W-1:0] exp_off;
   logic [127:0]      exp_ent;
   logic [ADDR_W-1:0] exp_addr[$];

   task automatic model(input logic [HASH_W-1:0] h, input logic [TAG_W-1:0] t,
                        input logic [4:0] ps, input logic [ADDR_W-1:0] b,
                        input logic [HASH_W-1:0] m);
      exp_addr.delete();
      exp_hit = 0;
      exp_off = '1;
      exp_ent = '0;
      for (int p = 0; p < 2 && !exp_hit; p++) begin
         logic [HASH_W-1:0] hh;
         hh = (p == 1) ? ~h : h;
         for (int i = 0; i < 8 && !exp_hit; i++) begin
            logic [ADDR_W-1:0] rel;
            logic [127:0] e;
            rel = grp_rel(hh, m) + ADDR_W'(i * 16);
            exp_addr.push_back(b + rel);
            e = rd(b + rel);
            if (e[0] && (e[1] == p[0]) && (e[63:7] == t) && size_pass(e[127:64], ps)) begin
               exp_hit = 1;
               exp_off = rel;
               exp_ent = e;
            end
         end
      end
   endtask

   function automatic logic [127:0] mk(input int kind, input bit sec,
                                       input logic [TAG_W-1:0] t, input logic [4:0] ps);
      logic [63:0] d0, d1;
      d1 = {$urandom, $urandom};
      if (ps == 5'd16) d1[15:12] = 4'd1;
      if (ps == 5'd24) d1[19:12] = 8'd0;
      d0 = {t, 5'b0, sec, 1'b1};
      case (kind)
         1: d0[0] = 1'b0;
         2: d0[1] = ~sec;
         3: d0[7] = ~d0[7];
         4: begin
            if (ps == 5'd16) d1[15:12] = 4'd2;
            if (ps == 5'd24) d1[19:12] = 8'h10;
         end
         default: ;
      endcase
      return {d1, d0};
   endfunction

   task automatic put(input logic [ADDR_W-1:0] b, input logic [HASH_W-1:0] h,
                      input logic [HASH_W-1:0] m, input int i, input logic [127:0] e);
      mem[b + grp_rel(h, m) + ADDR_W'(i * 16)] = e;
   endtask

   task automatic chk(input string rq, input string what, input bit ok,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic run(input string rq, input logic [HASH_W-1:0] h,
                      input logic [TAG_W-1:0] t, input logic [4:0] ps,
                      input logic [ADDR_W-1:0] b, input logic [HASH_W-1:0] m);
      int n;
      bit addr_ok;
      model(h, t, ps, b, m);
      got_q.delete();
      @(negedge clk);
      start = 1'b1; hash = h; tag = t; pshift = ps; tbl_base = b; tbl_mask = m;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(rq, "done seen", done, 128'(done), 128'(1));
      chk(rq, "hit", hit == exp_hit, 128'(hit), 128'(exp_hit));
      chk(rq, "offset", ent_offset == exp_off, 128'(ent_offset), 128'(exp_off));
      if (exp_hit)
         chk(rq, "entry data", {ent_dw1, ent_dw0} == exp_ent, {ent_dw1, ent_dw0}, exp_ent);
      chk(rq, "read count", got_q.size() == exp_addr.size(),
          128'(got_q.size()), 128'(exp_addr.size()));
      addr_ok = (got_q.size() == exp_addr.size());
      if (addr_ok) foreach (exp_addr[k]) if (got_q[k] != exp_addr[k]) addr_ok = 0;
      chk(rq, "R8 R9 address order", addr_ok, 128'(got_q.size()), 128'(exp_addr.size()));
      @(negedge clk);
      chk("R12", "done pulse held results",
          !done && hit == exp_hit && ent_offset == exp_off,
          {done, hit, ent_offset}, {1'b0, exp_hit, exp_off});
      mem.delete();
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [HASH_W-1:0] h, m;
      logic [TAG_W-1:0]  t;
      logic [ADDR_W-1:0] b;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R12", "reset idle", !busy && !done && !mem_req,
          {busy, done, mem_req}, 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      b = 40'h10_0000_0000; m = 20'hFF; h = 20'h00005;
      t = {$urandom, $urandom, $urandom};

      // R4: shift 12, hit at index 3 after non-matching entries
      put(b, h, m, 0, mk(1, 0, t, 12)); put(b, h, m, 1, mk(2, 0, t, 12));
      put(b, h, m, 2, mk(3, 0, t, 12)); put(b, h, m, 3, mk(4, 0, t, 12));
      run("R4", h, t, 12, b, m);

      // R5: shift 16, bad size at 0, good at 1
      put(b, h, m, 0, mk(4, 0, t, 16)); put(b, h, m, 1, mk(0, 0, t, 16));
      run("R5", h, t, 16, b, m);

      // R6: shift 24, bad size at 0, good at 5
      put(b, h, m, 0, mk(4, 0, t, 24)); put(b, h, m, 5, mk(0, 0, t, 24));
      run("R6", h, t, 24, b, m);

      // R7: unsupported shift rejects otherwise perfect entries in both groups
      for (int i = 0; i < 8; i++) begin
         put(b, h, m, i, mk(0, 0, t, 12)); put(b, ~h, m, i, mk(0, 1, t, 12));
      end
      run("R7", h, t, 20, b, m);

      // R2 R9: primary entries flagged secondary are skipped; secondary hit at 2
      for (int i = 0; i < 8; i++) put(b, h, m, i, mk(0, 1, t, 12));
      put(b, ~h, m, 2, mk(0, 1, t, 12));
      run("R2", h, t, 12, b, m);

      // R1: invalid perfect entry at 0, valid one at 7
      put(b, h, m, 0, mk(1, 0, t, 12)); put(b, h, m, 7, mk(0, 0, t, 12));
      run("R1", h, t, 12, b, m);

      // R3 R10: wrong tags everywhere -> miss, all-ones offset
      for (int i = 0; i < 8; i++) begin
         put(b, h, m, i, mk(3, 0, t, 12)); put(b, ~h, m, i, mk(3, 1, t, 12));
      end
      run("R10", h, t, 12, b, m);

      // R8: first match wins when two entries qualify
      put(b, h, m, 4, mk(0, 0, t, 16)); put(b, h, m, 6, mk(0, 0, t, 16));
      run("R8", h, t, 16, b, m);

      // Random mix
      for (int r = 0; r < 60; r++) begin
         logic [4:0] ps;
         int sel;
         h = HASH_W'($urandom);
         m = HASH_W'($urandom_range(0, 255));
         b = {8'h0, $urandom} & ~40'hF;
         t = {$urandom, $urandom, $urandom};
         sel = int'($urandom_range(0, 9));
         ps = (sel < 3) ? 5'd12 : (sel < 6) ? 5'd16 : (sel < 9) ? 5'd24 : 5'd20;
         for (int p = 0; p < 2; p++)
            for (int i = 0; i < 8; i++) begin
               int k;
               k = ($urandom_range(0, 11) == 0) ? 0 : int'($urandom_range(1, 4));
               put(b, (p == 1) ? ~h : h, m, i, mk(k, p[0], t, ps));
            end
         run("R8 R9 random", h, t, ps, b, m);
      end

      chk("R11", "one outstanding read", overlap_err == 0,
          128'(overlap_err), 128'(0));
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog R12 actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule